// File: doc/BRIEF.md
# Seven-Segment Digit Driver with Leading-Zero Suppression

This block turns one four-bit decimal digit into seven segment drives for a common-anode display. A segment line driven to 0 lights its segment and a line driven to 1 turns it off. Three active-low controls sit beside the digit. A dark request switches the whole digit off. A lamp-test request lights every segment. A zero-blank input asks the digit to stay dark if it is zero.

A zero-blank output tells the next lower digit that this digit blanked a leading zero. Several copies are placed side by side and chained to suppress leading zeros. The zero-blank input of the most significant digit is tied low. Each lower digit takes the zero-blank output of the digit above it. The least significant digit has its zero-blank input tied high, so a value of zero still shows one "0". The logic is purely combinational.

The digit resolves into one of four display modes, in this priority order: MODE_DARK (dark request low), MODE_TEST (lamp test low), MODE_SUPPRESS (zero-blank input low and digit equal to zero), and MODE_SHOW (all other cases).

Top module: `bcd7_digit_driver`

## Requirements
- R1: In MODE_SHOW with a digit from 0 to 9, seg_n_o carries the active-low pattern for that digit, with bit 0 driving segment a and bit 6 driving segment g. The hex values of seg_n_o for digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10.
- R2: In MODE_SHOW with a digit from 10 to 15, seg_n_o is 7F, so every segment is off.
- R3: When dark_n_i is high and lamp_test_n_i is low, seg_n_o is 00 whatever the digit and the zero-blank input are.
- R4: When dark_n_i is low, seg_n_o is 7F and zero_blank_out_n_o is high, whatever the other inputs are.
- R5: When dark_n_i and lamp_test_n_i are high, zero_blank_in_n_i is low and the digit is 0, seg_n_o is 7F and zero_blank_out_n_o is low.
- R6: When zero_blank_in_n_i is low and the digit is nonzero, with dark_n_i and lamp_test_n_i high, the digit decodes as in R1 or R2 and zero_blank_out_n_o stays high.
- R7: zero_blank_out_n_o is high in every case other than the one in R5, including during lamp test.
- R8: In a chain built as described above, the leading zeros are dark. The first nonzero digit and every digit below it are shown, including inner zeros. The least significant digit is always shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_i | input | 4 | Binary-coded decimal digit to show |
| lamp_test_n_i | input | 1 | Active-low lamp test that lights all segments |
| dark_n_i | input | 1 | Active-low request that switches the digit off |
| zero_blank_in_n_i | input | 1 | Active-low request to blank this digit if it is zero |
| seg_n_o | output | 7 | Active-low segment drives, with a at bit 0 and g at bit 6 |
| zero_blank_out_n_o | output | 1 | Active-low flag that this digit blanked a zero |

## Verification
The block has no parameters of its own that change behaviour. The bench builds one free-standing copy and a chain of four copies, with the chain length held in a bench localparam. The free-standing copy is driven through all 16 codes under all 8 combinations of the three controls. This reaches every mode and every priority clash. The four-digit chain sweeps every decimal value from 0000 to 9999. This exercises leading, inner and trailing zeros, including the all-zero value that must still show one digit.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int MAX_DEC = 9;

    localparam logic [SEG_W-1:0] SEG_ALL_OFF = {SEG_W{1'b1}};
    localparam logic [SEG_W-1:0] SEG_ALL_ON  = {SEG_W{1'b0}};

    typedef enum logic [1:0] {
        MODE_DARK,
        MODE_TEST,
        MODE_SUPPRESS,
        MODE_SHOW
    } disp_mode_e;

endpackage

// File: rtl/bcd7_glyph_rom.sv
module bcd7_glyph_rom
    import bcd7_pkg::*;
(
    input  logic [DIGIT_W-1:0] code_i,
    output logic [SEG_W-1:0]   glyph_n_o
);

    logic [SEG_W-1:0] lit;

    always_comb begin
        unique case (code_i)
            4'd0:    lit = 7'b0111111;
            4'd1:    lit = 7'b0000110;
            4'd2:    lit = 7'b1011011;
            4'd3:    lit = 7'b1001111;
            4'd4:    lit = 7'b1100110;
            4'd5:    lit = 7'b1101101;
            4'd6:    lit = 7'b1111101;
            4'd7:    lit = 7'b0000111;
            4'd8:    lit = 7'b1111111;
            4'd9:    lit = 7'b1101111;
            default: lit = 7'b0000000;
        endcase
    end

    // common-anode drive: a lit segment is pulled low
    assign glyph_n_o = ~lit;

endmodule

// File: rtl/bcd7_mode_sel.sv
module bcd7_mode_sel
    import bcd7_pkg::*;
(
    input  logic [DIGIT_W-1:0] code_i,
    input  logic               lamp_test_n_i,
    input  logic               dark_n_i,
    input  logic               zero_blank_in_n_i,
    output disp_mode_e         mode_o
);

    logic is_zero;

    assign is_zero = (code_i == '0);

    // priority: dark > lamp test > zero suppression > show
    always_comb begin
        if (!dark_n_i)
            mode_o = MODE_DARK;
        else if (!lamp_test_n_i)
            mode_o = MODE_TEST;
        else if (!zero_blank_in_n_i && is_zero)
            mode_o = MODE_SUPPRESS;
        else
            mode_o = MODE_SHOW;
    end

endmodule

// File: rtl/bcd7_digit_driver.sv
module bcd7_digit_driver
    import bcd7_pkg::*;
(
    input  logic [3:0] digit_i,
    input  logic       lamp_test_n_i,
    input  logic       dark_n_i,
    input  logic       zero_blank_in_n_i,
    output logic [6:0] seg_n_o,
    output logic       zero_blank_out_n_o
);

    disp_mode_e       mode;
    logic [SEG_W-1:0] glyph_n;

    bcd7_mode_sel u_mode_sel (
        .code_i            (digit_i),
        .lamp_test_n_i     (lamp_test_n_i),
        .dark_n_i          (dark_n_i),
        .zero_blank_in_n_i (zero_blank_in_n_i),
        .mode_o            (mode)
    );

    bcd7_glyph_rom u_glyph_rom (
        .code_i    (digit_i),
        .glyph_n_o (glyph_n)
    );

    always_comb begin
        unique case (mode)
            MODE_DARK: begin
                seg_n_o            = SEG_ALL_OFF;
                zero_blank_out_n_o = 1'b1;
            end
            MODE_TEST: begin
                seg_n_o            = SEG_ALL_ON;
                zero_blank_out_n_o = 1'b1;
            end
            MODE_SUPPRESS: begin
                seg_n_o            = SEG_ALL_OFF;
                zero_blank_out_n_o = 1'b0;
            end
            MODE_SHOW: begin
                seg_n_o            = glyph_n;
                zero_blank_out_n_o = 1'b1;
            end
            default: begin
                seg_n_o            = SEG_ALL_OFF;
                zero_blank_out_n_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bcd7_digit_driver_chk.sv
module bcd7_digit_driver_chk (
    input logic [3:0] digit_i,
    input logic       lamp_test_n_i,
    input logic       dark_n_i,
    input logic       zero_blank_in_n_i,
    input logic [6:0] seg_n_o,
    input logic       zero_blank_out_n_o
);

    logic known;
    logic live;

    assign known = !$isunknown({digit_i, lamp_test_n_i, dark_n_i, zero_blank_in_n_i});
    assign live  = dark_n_i && lamp_test_n_i;

    always_comb begin
        if (known) begin
            if (!dark_n_i) begin
                a_r4_dark_wins: assert (seg_n_o == 7'h7F && zero_blank_out_n_o);
            end
            if (dark_n_i && !lamp_test_n_i) begin
                a_r3_all_lit: assert (seg_n_o == 7'h00 && zero_blank_out_n_o);
            end
            if (live && !zero_blank_in_n_i && digit_i == 4'd0) begin
                a_r5_zero_hidden: assert (seg_n_o == 7'h7F && !zero_blank_out_n_o);
            end
            if (live && digit_i > 4'd9) begin
                a_r2_bad_code_off: assert (seg_n_o == 7'h7F);
            end
            if (live && !zero_blank_in_n_i && digit_i != 4'd0) begin
                a_r6_nonzero_passes: assert (zero_blank_out_n_o);
            end
            a_r7_flag_only_on_blank: assert (zero_blank_out_n_o ||
                (live && !zero_blank_in_n_i && digit_i == 4'd0));
        end
    end

endmodule

bind bcd7_digit_driver bcd7_digit_driver_chk u_chk (
    .digit_i            (digit_i),
    .lamp_test_n_i      (lamp_test_n_i),
    .dark_n_i           (dark_n_i),
    .zero_blank_in_n_i  (zero_blank_in_n_i),
    .seg_n_o            (seg_n_o),
    .zero_blank_out_n_o (zero_blank_out_n_o)
);

// File: tb/bcd7_digit_driver_bench.sv
module bcd7_digit_driver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DIGITS = 4;
    localparam int WATCHDOG   = 150000;

    logic clk;
    logic rst_n;
    int   n_checks;
    int   n_errors;
    int   cycles;

    // free-standing copy
    logic [3:0] s_digit;
    logic       s_lt_n, s_dark_n, s_zb_n;
    logic [6:0] s_seg;
    logic       s_zbo;

    // chain
    logic [3:0] c_digit [NUM_DIGITS];
    logic       c_lt_n, c_dark_n;
    logic [6:0] c_seg   [NUM_DIGITS];
    logic       c_zbo   [NUM_DIGITS];
    logic       c_zbi   [NUM_DIGITS];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    bcd7_digit_driver u_bcd7_digit_driver (
        .digit_i            (s_digit),
        .lamp_test_n_i      (s_lt_n),
        .dark_n_i           (s_dark_n),
        .zero_blank_in_n_i  (s_zb_n),
        .seg_n_o            (s_seg),
        .zero_blank_out_n_o (s_zbo)
    );

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chain
        if (i == NUM_DIGITS-1) begin : g_top
            assign c_zbi[i] = 1'b0;
        end else if (i == 0) begin : g_low
            assign c_zbi[i] = 1'b1;
        end else begin : g_mid
            assign c_zbi[i] = c_zbo[i+1];
        end
        bcd7_digit_driver u_bcd7_digit_driver (
            .digit_i            (c_digit[i]),
            .lamp_test_n_i      (c_lt_n),
            .dark_n_i           (c_dark_n),
            .zero_blank_in_n_i  (c_zbi[i]),
            .seg_n_o            (c_seg[i]),
            .zero_blank_out_n_o (c_zbo[i])
        );
    end

    // behavioural reference: glyphs from the R1 table
    function automatic logic [6:0] ref_glyph(input int d);
        case (d)
            0: return 7'h40;
            1: return 7'h79;
            2: return 7'h24;
            3: return 7'h30;
            4: return 7'h19;
            5: return 7'h12;
            6: return 7'h02;
            7: return 7'h78;
            8: return 7'h00;
            9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic [7:0] ref_digit(input int d, input logic lt_n,
                                             input logic dk_n, input logic zb_n);
        if (!dk_n)                return {1'b1, 7'h7F};
        else if (!lt_n)           return {1'b1, 7'h00};
        else if (!zb_n && d == 0) return {1'b0, 7'h7F};
        else                      return {1'b1, ref_glyph(d)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got flag=%b seg=%h, expected flag=%b seg=%h",
                     req, act[7], act[6:0], exp[7], exp[6:0]);
        end
    endtask

    // compare both the lone copy and the chain on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            string tag;
            int    d;
            logic  zb;
            d = int'(s_digit);
            if (!s_dark_n)                 tag = "R4";
            else if (!s_lt_n)              tag = "R3";
            else if (!s_zb_n && d == 0)    tag = "R5";
            else if (d > 9)                tag = "R2";
            else if (!s_zb_n)              tag = "R6";
            else                           tag = "R1";
            check(tag, {1'b0, s_seg}, {1'b0, ref_digit(d, s_lt_n, s_dark_n, s_zb_n) & 8'h7F});
            check((tag == "R1" || tag == "R2" || tag == "R3") ? "R7" : tag,
                  {s_zbo, 7'h00}, {ref_digit(d, s_lt_n, s_dark_n, s_zb_n) & 8'h80});
            zb = 1'b0;
            for (int i = NUM_DIGITS-1; i >= 0; i--) begin
                logic [7:0] e;
                logic       zin;
                zin = (i == NUM_DIGITS-1) ? 1'b0 : (i == 0) ? 1'b1 : zb;
                e   = ref_digit(int'(c_digit[i]), c_lt_n, c_dark_n, zin);
                check("R8", {c_zbo[i], c_seg[i]}, e);
                zb  = e[7];
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        n_checks = 0;
        n_errors = 0;
        cycles   = 0;
        rst_n    = 1'b0;
        s_digit  = 4'd0;
        s_lt_n   = 1'b1;
        s_dark_n = 1'b0;
        s_zb_n   = 1'b0;
        c_lt_n   = 1'b1;
        c_dark_n = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++) c_digit[i] = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: dark request held low, digit must be off (R4)
        check("R4", {s_zbo, s_seg}, {1'b1, 7'h7F});
        @(posedge clk);
        rst_n = 1'b1;

        // exhaustive single-digit sweep: 16 codes x 8 control combos
        for (int ctl = 0; ctl < 8; ctl++) begin
            for (int d = 0; d < 16; d++) begin
                @(posedge clk);
                s_digit  = 4'(d);
                s_dark_n = ctl[2];
                s_lt_n   = ctl[1];
                s_zb_n   = ctl[0];
            end
        end

        // chain sweep 0000..9999 in normal operation (R8)
        for (int v = 0; v < 10000; v++) begin
            @(posedge clk);
            c_digit[0] = 4'(v % 10);
            c_digit[1] = 4'((v / 10) % 10);
            c_digit[2] = 4'((v / 100) % 10);
            c_digit[3] = 4'(v / 1000);
        end

        // chain with lamp test and dark request over a leading-zero value
        @(posedge clk);
        c_digit[3] = 4'd0; c_digit[2] = 4'd0; c_digit[1] = 4'd5; c_digit[0] = 4'd0;
        c_lt_n = 1'b0;
        @(posedge clk);
        c_dark_n = 1'b0;
        @(posedge clk);
        c_lt_n = 1'b1;
        @(posedge clk);
        c_dark_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule